// File: doc/BRIEF.md
# Glitch-Free Clock Multiplexer

This block picks one of two clock sources and drives it onto a single output clock. The two sources may be fully unrelated in frequency and phase. A change of the select never produces a runt pulse: the lane that is running is stopped low on its own falling edge, and only after that is seen is the other lane allowed to run. Each source has its own lane, made of a short falling-edge synchronizer chain and an AND gate on the source clock. The output is the OR of the two gated lanes.

With the select held steady the block is a plain clock buffer. The active-high enable turns it into a clock gate that always parks the output low and never cuts a high phase short. Reset is active low and is sampled on each source's falling edge. The reset state has the first source running, so a design that holds the select low sees a clock during and straight after reset.

The select must stay put for at least 2*SYNC_STAGES+2 periods of the slower source, long enough for a handover to finish. The enable may toggle at any rate.

Top module: `gcm_top`

## Requirements
- R1: With sel_i low and ce_i high, once the inputs have been steady long enough for a handover, clk_o equals clk_a_i at every instant.
- R2: With sel_i high and ce_i high, once settled, clk_o equals clk_b_i. A lane opens its gate only if its request was seen within its last SYNC_STAGES falling edges. A lane's request is ce_i high together with the select naming that lane: low names lane A, high names lane B.
- R3: The two lane gates are never open together. A newly chosen lane opens only after it has seen the other lane's gate closed.
- R4: Every high pulse on clk_o is one whole high phase of a source clock. Every low pulse is at least as long as the shorter source half period.
- R5: While ce_i is low, the active lane's gate closes within SYNC_STAGES of its falling edges and clk_o then stays low. No high pulse is cut short. Raising ce_i again restarts the selected clock.
- R6: While rst_n is low, lane A's gate is forced open and lane B's is forced closed on each lane's falling edge. With sel_i low, clk_o therefore follows clk_a_i during and after reset.
- R7: Across a change of source, clk_o stays low for at least one full period of each source clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a_i | input | 1 | First source clock, chosen when sel_i is low |
| clk_b_i | input | 1 | Second source clock, chosen when sel_i is high |
| rst_n | input | 1 | Active-low reset, sampled on each source's falling edge |
| sel_i | input | 1 | Source select, asynchronous to both clocks |
| ce_i | input | 1 | Active-high clock enable; low parks the output low |
| clk_o | output | 1 | Multiplexed, glitch-free output clock |

## Verification
The assertions check three things on every edge of the source clocks: the two gates are never open at once, a gate opens only after a recent request for its lane, and an enable held low for SYNC_STAGES falling edges leaves the gate closed. Pulse shapes on the output are left to the bench's scenarios, because they depend on the real clock ratios. The bench measures every output high and low pulse, checks the quiet gap around each handover, and compares the settled output against the selected source. This covers reset, both sources, enable toggling faster than the synchronizers, and switching while gated off.

// File: rtl/gcm_pkg.sv
// Shared constants and helpers for the glitch-free clock multiplexer.
// Assumes exactly two sources; lane 0 is the sel-low source.
package gcm_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int unsigned GCM_NUM_SRC  = 2;
    localparam int unsigned GCM_DEF_SYNC = 2;

    // Whether a lane is requested by the current select/enable pair.
    function automatic logic lane_wanted(input int unsigned lane,
                                         input logic        sel,
                                         input logic        ce);
        logic pick;
        pick = (lane == 0) ? ~sel : sel;
        return ce & pick;
    endfunction
endpackage

// File: rtl/gcm_sync.sv
// Falling-edge synchronizer chain with a synchronous active-low reset.
// Assumes STAGES >= 1; the reset value fills every stage so a lane can
// come out of reset already open or already closed.
module gcm_sync #(
    parameter int unsigned STAGES    = 2,
    parameter bit          RESET_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [STAGES-1:0] chain_q;

    // Shift the request through the chain on each falling edge.
    always_ff @(negedge clk_i) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q[0] <= d_i;
            for (int i = 1; i < int'(STAGES); i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gcm_lane.sv
// One source lane: forms the lane request (wanted and other lane closed),
// passes it through the falling-edge synchronizer, and gates the source.
// Because the gate only changes while the source is low, the gated clock
// carries whole high phases only.
module gcm_lane #(
    parameter int unsigned STAGES   = 2,
    parameter bit          RESET_ON = 1'b0
) (
    input  logic clk_i,
    input  logic rst_n,
    input  logic want_i,
    input  logic other_on_i,
    output logic gate_o,
    output logic clk_o
);
    timeunit 1ns;
    timeprecision 100ps;

    logic request;

    // Break-before-make: ask only while the other lane is seen closed.
    assign request = want_i & ~other_on_i;

    gcm_sync #(
        .STAGES   (STAGES),
        .RESET_VAL(RESET_ON)
    ) u_sync (
        .clk_i(clk_i),
        .rst_n(rst_n),
        .d_i  (request),
        .q_o  (gate_o)
    );

    // Gate the source with a gate that is stable while the source is high.
    assign clk_o = clk_i & gate_o;
endmodule

// File: rtl/gcm_top.sv
// Two-source glitch-free clock multiplexer with a stop-low clock enable.
// Assumes sel_i is held for a full handover; ce_i may change at any time.
module gcm_top #(
    parameter int unsigned SYNC_STAGES = gcm_pkg::GCM_DEF_SYNC
) (
    input  logic clk_a_i,
    input  logic clk_b_i,
    input  logic rst_n,
    input  logic sel_i,
    input  logic ce_i,
    output logic clk_o
);
    timeunit 1ns;
    timeprecision 100ps;
    import gcm_pkg::*;

    logic [GCM_NUM_SRC-1:0] src_clk;
    logic [GCM_NUM_SRC-1:0] want;
    logic [GCM_NUM_SRC-1:0] gate_q;
    logic [GCM_NUM_SRC-1:0] lane_clk;

    // Collect the sources into a vector indexed by lane.
    assign src_clk = {clk_b_i, clk_a_i};

    for (genvar g = 0; g < int'(GCM_NUM_SRC); g++) begin : g_lane
        localparam int unsigned OTHER = GCM_NUM_SRC - 1 - g;

        // Decode the request for this lane.
        assign want[g] = lane_wanted(g, sel_i, ce_i);

        gcm_lane #(
            .STAGES  (SYNC_STAGES),
            .RESET_ON(g == 0)
        ) u_lane (
            .clk_i     (src_clk[g]),
            .rst_n     (rst_n),
            .want_i    (want[g]),
            .other_on_i(gate_q[OTHER]),
            .gate_o    (gate_q[g]),
            .clk_o     (lane_clk[g])
        );
    end

    // Merge the lanes; at most one gate is open at a time.
    assign clk_o = |lane_clk;
endmodule

// File: rtl/gcm_checker.sv
// Checker for gcm_top: gate exclusivity, gate opening only on request,
// and the stop-low enable. Attached with bind below.
module gcm_checker #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input logic       clk_a_i,
    input logic       clk_b_i,
    input logic       rst_n,
    input logic       sel_i,
    input logic       ce_i,
    input logic       clk_o,
    input logic [1:0] gate_q
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int unsigned AW = $clog2(SYNC_STAGES + 1) + 1;
    localparam logic [AW-1:0] LIMIT = AW'(SYNC_STAGES);

    logic [1:0] src_clk;
    assign src_clk = {clk_b_i, clk_a_i};

    for (genvar g = 0; g < 2; g++) begin : g_chk
        logic [AW-1:0] off_run;
        logic [AW-1:0] want_age;
        logic          want_s;

        // Request for this lane as seen by the checker.
        assign want_s = ce_i & ((g == 0) ? ~sel_i : sel_i);

        // Count falling edges with the enable low, and edges since the last request.
        always_ff @(negedge src_clk[g]) begin
            if (!rst_n) begin
                off_run  <= '0;
                want_age <= LIMIT;
            end else begin
                if (ce_i) off_run <= '0;
                else if (off_run < LIMIT) off_run <= off_run + 1'b1;
                if (want_s) want_age <= '0;
                else if (want_age < LIMIT) want_age <= want_age + 1'b1;
            end
        end

        AST_NO_DOUBLE_GATE: assert property (@(posedge src_clk[g]) disable iff (!rst_n) !(gate_q[0] && gate_q[1])); // R3
        AST_OPEN_ON_REQUEST: assert property (@(negedge src_clk[g]) disable iff (!rst_n) $rose(gate_q[g]) |-> (want_age < LIMIT)); // R2
        AST_ENABLE_STOPS_LOW: assert property (@(negedge src_clk[g]) disable iff (!rst_n) (off_run >= LIMIT) |-> !gate_q[g]); // R5
    end

    AST_IDLE_OUTPUT_LOW: assert property (@(posedge clk_a_i) disable iff (!rst_n) (gate_q == 2'b00) |-> !clk_o); // R5

    logic unused_ok;
    assign unused_ok = clk_o;
endmodule

bind gcm_top gcm_checker #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk_a_i(clk_a_i),
    .clk_b_i(clk_b_i),
    .rst_n  (rst_n),
    .sel_i  (sel_i),
    .ce_i   (ce_i),
    .clk_o  (clk_o),
    .gate_q (gate_q)
);

// File: tb/test_gcm_top.sv
// Bench for gcm_top: two unrelated clocks, a behavioural reference for the
// settled output, and a pulse-width monitor on every output edge.
module test_gcm_top;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int  CLK_PERIOD   = 10;
    localparam int  CLK_B_PERIOD = 14;
    localparam real HALF_A       = CLK_PERIOD / 2.0;
    localparam real HALF_B       = CLK_B_PERIOD / 2.0;
    localparam real SETTLE       = 120.0;
    localparam real MIN_GAP      = CLK_B_PERIOD;
    localparam int  HOLD         = 200;

    logic clk_a = 1'b0;
    logic clk_b = 1'b0;
    logic rst_n = 1'b0;
    logic sel   = 1'b0;
    logic ce    = 1'b1;
    logic clk_o;

    int  n_cmp  = 0;
    int  n_bad  = 0;
    bit  cmp_on = 1'b0;
    bit  mon_on = 1'b0;
    bit  in_rst = 1'b1;
    real t_change = -1000.0;
    real t_edge   = -1.0;
    real max_low  = 0.0;

    gcm_top i_gcm_top (
        .clk_a_i(clk_a),
        .clk_b_i(clk_b),
        .rst_n  (rst_n),
        .sel_i  (sel),
        .ce_i   (ce),
        .clk_o  (clk_o)
    );

    always #(HALF_A) clk_a = ~clk_a;
    always #(HALF_B) clk_b = ~clk_b;

    task automatic fail_line(input string req, input string what, input string got, input string exp_s);
        n_bad++;
        $display("FAIL %s %s: actual %s expected %s at %0t", req, what, got, exp_s, $realtime);
    endtask

    // Reference: a settled output equals the chosen source, or low when disabled.
    initial begin
        #0.5;
        forever begin
            if (cmp_on && ($realtime - t_change >= SETTLE)) begin
                logic  expv;
                string req;
                expv = !ce ? 1'b0 : (sel ? clk_b : clk_a);
                req  = in_rst ? "R6" : (!ce ? "R5" : (sel ? "R2" : "R1"));
                n_cmp++;
                if (clk_o !== expv)
                    fail_line(req, "settled output", $sformatf("%b", clk_o), $sformatf("%b", expv));
            end
            #1;
        end
    end

    // Pulse monitor: whole high phases, low phases no shorter than the short half period.
    always @(clk_o) begin
        if (mon_on) begin
            if (t_edge >= 0.0) begin
                real w;
                w = $realtime - t_edge;
                n_cmp++;
                if (clk_o === 1'b0) begin
                    if (!(w == HALF_A || w == HALF_B))
                        fail_line("R4", "high pulse", $sformatf("%0.1f", w), "5.0 or 7.0");
                end else begin
                    if (w < HALF_A)
                        fail_line("R4", "low pulse", $sformatf("%0.1f", w), ">=5.0");
                    if (w > max_low) max_low = w;
                end
            end
            t_edge = $realtime;
        end
    end

    task automatic set_ce(input logic v);
        ce = v;
        t_change = $realtime;
    endtask

    // Change source, wait out the handover, then check the quiet gap.
    task automatic do_switch(input logic s, input bit check_gap);
        sel = s;
        t_change = $realtime;
        max_low = 0.0;
        #(HOLD);
        if (check_gap) begin
            n_cmp++;
            if (max_low < MIN_GAP)
                fail_line("R3 R7", "handover gap", $sformatf("%0.1f", max_low), ">=14.0");
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #0.3;
        // R6: reset state with sel low, compared during reset too.
        #20 cmp_on = 1'b1;
        #40 rst_n = 1'b1;
        mon_on = 1'b1;
        #150 in_rst = 1'b0;
        #50;
        // R1, R2, R7: handovers in both directions.
        do_switch(1'b1, 1'b1);
        do_switch(1'b0, 1'b1);
        // R5: gate off on A, then back on.
        set_ce(1'b0); #(HOLD);
        set_ce(1'b1); #(HOLD);
        // R5, R2: switch while disabled, then enable on B.
        set_ce(1'b0); #(HOLD);
        do_switch(1'b1, 1'b0);
        set_ce(1'b1); #(HOLD);
        // R4, R5: enable toggled faster than the synchronizers.
        for (int k = 0; k < 24; k++) begin
            set_ce(~ce);
            #(3 + (k % 4) * 2);
        end
        set_ce(1'b1); #(HOLD);
        do_switch(1'b0, 1'b1);
        for (int k = 0; k < 16; k++) begin
            set_ce(~ce);
            #(4 + (k % 3) * 3);
        end
        set_ce(1'b1); #(HOLD);
        do_switch(1'b1, 1'b1);
        do_switch(1'b0, 1'b1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule